// File: doc/BRIEF.md
# Byte-Wide Serial Controller Host Register Bank

This block is the processor-side register file of a classic byte-oriented serial controller. A host reaches it through a 3-bit register offset, a three-line chip-select pattern and separate active-low read and write strobes. The most significant bit of the line control register switches offsets 0 and 1 between the data/interrupt-enable registers and the two bytes of a 16-bit baud divisor.

Bytes written to the transmit holding register move into a one-entry shift stage that is not visible to the host. That stage presents each byte to the serial engine with a valid/done handshake. Received bytes arrive on a parallel strobe and are latched into the receive buffer. Line status, interrupt identification and a level interrupt output report data-ready, overrun and transmit-holding-empty conditions.

Top module: `serhost_regs`

## Requirements
- R1: An access takes place only when `csel_p0`=1, `csel_p1`=1 and `csel_n`=0. With any other pattern, writes change nothing and `rdata` is 0.
- R2: A read needs `rd_strb_n`=0 with `wr_strb_n`=1, and a write needs the reverse. With both strobes low, nothing happens. Whenever no read is active, `rdata` is 0.
- R3: With the divisor-access bit clear, a write at offset 0 loads the transmit holding register and a read at offset 0 returns the receive buffer.
- R4: Bit 7 of the line control register (offset 3, read/write, all 8 bits kept) is the divisor-access bit. While it is set, offsets 0 and 1 read and write the divisor low and high bytes, and neither the transmit holding register nor the interrupt enables are touched.
- R5: The interrupt enables sit at offset 1 (divisor-access bit clear). Only the low 4 bits are stored, and bits 7:4 read as 0. Bit 0 enables data-ready and bit 1 enables holding-empty.
- R6: When the holding register is full and the shift stage is idle, the byte moves on the next clock edge. `tx_valid` then stays high with `tx_byte` stable until a cycle with `tx_done`=1. A host write in the same cycle as that move leaves the new byte in the holding register.
- R7: Line status at offset 5 reads bit 0 data-ready, bit 1 overrun and bit 5 holding-empty, with all other bits 0. Holding-empty clears on a holding-register write and sets when the byte moves on.
- R8: `rx_valid` latches `rx_byte` into the receive buffer and sets data-ready. A receive-buffer read clears data-ready, but an arrival in the same cycle keeps it set. An arrival while data-ready is set and the buffer is not being read sets overrun. A line status read clears overrun.
- R9: `irq` = (data-ready AND enable bit 0) OR (holding-empty pending AND enable bit 1). The pending flag sets when a byte moves into the shift stage and clears on a holding-register write.
- R10: Offset 2 reads 0x04 for enabled data-ready, else 0x02 for enabled holding-empty pending, else 0x01. A read that returns 0x02 clears the pending flag.
- R11: After reset, the line control register, interrupt enables and divisor are 0. Line status reads 0x20, and `irq` and `tx_valid` are 0.
- R12: Writes at offsets 2, 4, 5, 6 and 7 have no effect. Reads at offsets 4, 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csel_p0 | input | 1 | Chip select, must be 1 |
| csel_p1 | input | 1 | Chip select, must be 1 |
| csel_n | input | 1 | Chip select, must be 0 |
| reg_off | input | 3 | Register offset |
| rd_strb_n | input | 1 | Active-low read strobe |
| wr_strb_n | input | 1 | Active-low write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not reading |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Shift stage holds a byte |
| tx_byte | output | 8 | Byte in the shift stage |
| tx_done | input | 1 | Serial engine consumed the byte |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land in one cycle. In the first, a host write to the holding register coincides with the edge at which the previous byte moves into a just-freed shift stage. In the second, a received byte arrives in the same cycle as a receive-buffer read. The bench builds both by releasing the shift stage with `tx_done` one cycle before a write, and by pulsing `rx_valid` during a read at offset 0. It then judges the outcome from the moved byte on `tx_byte`, the holding-empty bit, the pending interrupt, and the data-ready and overrun bits read back from line status. A randomized phase then overlaps strobes, arrivals and completions freely against the cycle model.

// File: rtl/serhost_pkg.sv
package serhost_pkg;
    localparam int BYTE_W  = 8;
    localparam int OFF_W   = 3;
    localparam int IEN_W   = 4;
    localparam int DL_BYTES = 2;

    typedef enum logic [OFF_W-1:0] {
        OFF_DATA  = 3'd0,
        OFF_IEN   = 3'd1,
        OFF_IID   = 3'd2,
        OFF_LCTL  = 3'd3,
        OFF_MCTL  = 3'd4,
        OFF_LSTAT = 3'd5,
        OFF_MSTAT = 3'd6,
        OFF_SPARE = 3'd7
    } off_e;

    typedef enum logic [2:0] {
        T_NONE, T_RXTX, T_IEN, T_DLLO, T_DLHI, T_IID, T_LCTL, T_LSTAT
    } tgt_e;

    typedef struct packed {
        logic rd;
        logic wr;
        tgt_e tgt;
    } acc_t;

    localparam int LCTL_DLAB_BIT = BYTE_W - 1;
    localparam int IEN_RX_BIT    = 0;
    localparam int IEN_TX_BIT    = 1;

    localparam logic [BYTE_W-1:0] IID_NONE  = 8'h01;
    localparam logic [BYTE_W-1:0] IID_TXEMP = 8'h02;
    localparam logic [BYTE_W-1:0] IID_RXRDY = 8'h04;

    function automatic logic [BYTE_W-1:0] lstat_pack(input logic dr, input logic oe,
                                                     input logic thre);
        logic [BYTE_W-1:0] v;
        v    = '0;
        v[0] = dr;
        v[1] = oe;
        v[5] = thre;
        return v;
    endfunction
endpackage

// File: rtl/serhost_decode.sv
module serhost_decode
    import serhost_pkg::*;
(
    input  logic             csel_p0,
    input  logic             csel_p1,
    input  logic             csel_n,
    input  logic [OFF_W-1:0] off,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             dlab,
    output acc_t             acc
);
    logic hit;

    always_comb begin
        hit    = csel_p0 & csel_p1 & ~csel_n;
        acc.rd = hit & ~rd_n & wr_n;
        acc.wr = hit & ~wr_n & rd_n;
        case (off_e'(off))
            OFF_DATA:  acc.tgt = dlab ? T_DLLO : T_RXTX;
            OFF_IEN:   acc.tgt = dlab ? T_DLHI : T_IEN;
            OFF_IID:   acc.tgt = T_IID;
            OFF_LCTL:  acc.tgt = T_LCTL;
            OFF_LSTAT: acc.tgt = T_LSTAT;
            default:   acc.tgt = T_NONE;
        endcase
        if (!hit) acc.tgt = T_NONE;
    end
endmodule

// File: rtl/serhost_txpath.sv
module serhost_txpath #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         thr_wr,
    input  logic [W-1:0] wdata,
    input  logic         tx_done,
    output logic         thr_empty,
    output logic         moved,
    output logic         tx_valid,
    output logic [W-1:0] tx_byte
);
    logic [W-1:0] thr_q, tsr_q;
    logic         thr_full, tsr_busy;

    assign moved     = thr_full & ~tsr_busy;
    assign thr_empty = ~thr_full;
    assign tx_valid  = tsr_busy;
    assign tx_byte   = tsr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q    <= '0;
            tsr_q    <= '0;
            thr_full <= 1'b0;
            tsr_busy <= 1'b0;
        end else begin
            if (tsr_busy && tx_done) tsr_busy <= 1'b0;
            if (moved) begin
                tsr_q    <= thr_q;
                tsr_busy <= 1'b1;
            end
            if (thr_wr) begin
                thr_q    <= wdata;
                thr_full <= 1'b1;
            end else if (moved) begin
                thr_full <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/serhost_rxpath.sv
module serhost_rxpath #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_byte,
    input  logic         rbr_rd,
    input  logic         lsr_rd,
    output logic [W-1:0] rbr,
    output logic         dr,
    output logic         oe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rbr <= '0;
            dr  <= 1'b0;
            oe  <= 1'b0;
        end else begin
            if (rx_valid) begin
                rbr <= rx_byte;
                dr  <= 1'b1;
            end else if (rbr_rd) begin
                dr  <= 1'b0;
            end
            if (rx_valid && dr && !rbr_rd) oe <= 1'b1;
            else if (lsr_rd)               oe <= 1'b0;
        end
    end
endmodule

// File: rtl/serhost_regs.sv
module serhost_regs
    import serhost_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int AW = OFF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          csel_p0,
    input  logic          csel_p1,
    input  logic          csel_n,
    input  logic [AW-1:0] reg_off,
    input  logic          rd_strb_n,
    input  logic          wr_strb_n,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    output logic          tx_valid,
    output logic [DW-1:0] tx_byte,
    input  logic          tx_done,
    output logic          irq
);
    localparam int DL_W = DW * DL_BYTES;

    acc_t             acc;
    logic [DW-1:0]    lcr_q;
    logic [IEN_W-1:0] ier_q;
    logic [DL_W-1:0]  dl_q;
    logic             pend_q;
    logic             dlab;
    logic             thr_wr, thr_empty, moved;
    logic [DW-1:0]    rbr;
    logic             dr_q, oe_q;
    logic             rx_irq, tx_irq;
    logic [DW-1:0]    iid;
    logic             iid_tx_rd;

    assign dlab = lcr_q[LCTL_DLAB_BIT];

    serhost_decode u_dec (
        .csel_p0(csel_p0), .csel_p1(csel_p1), .csel_n(csel_n),
        .off(reg_off), .rd_n(rd_strb_n), .wr_n(wr_strb_n),
        .dlab(dlab), .acc(acc)
    );

    assign thr_wr = acc.wr && (acc.tgt == T_RXTX);

    serhost_txpath #(.W(DW)) u_tx (
        .clk(clk), .rst(rst), .thr_wr(thr_wr), .wdata(wdata),
        .tx_done(tx_done), .thr_empty(thr_empty), .moved(moved),
        .tx_valid(tx_valid), .tx_byte(tx_byte)
    );

    serhost_rxpath #(.W(DW)) u_rx (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rbr_rd(acc.rd && (acc.tgt == T_RXTX)),
        .lsr_rd(acc.rd && (acc.tgt == T_LSTAT)),
        .rbr(rbr), .dr(dr_q), .oe(oe_q)
    );

    assign rx_irq = dr_q & ier_q[IEN_RX_BIT];
    assign tx_irq = pend_q & ier_q[IEN_TX_BIT];
    assign irq    = rx_irq | tx_irq;

    always_comb begin
        if (rx_irq)      iid = IID_RXRDY;
        else if (tx_irq) iid = IID_TXEMP;
        else             iid = IID_NONE;
    end

    assign iid_tx_rd = acc.rd && (acc.tgt == T_IID) && (iid == IID_TXEMP);

    // divisor bytes: one register slice per byte
    for (genvar b = 0; b < DL_BYTES; b++) begin : g_dl
        always_ff @(posedge clk) begin
            if (rst) begin
                dl_q[b*DW +: DW] <= '0;
            end else if (acc.wr && (acc.tgt == ((b == 0) ? T_DLLO : T_DLHI))) begin
                dl_q[b*DW +: DW] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lcr_q  <= '0;
            ier_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (acc.wr && acc.tgt == T_LCTL) lcr_q <= wdata;
            if (acc.wr && acc.tgt == T_IEN)  ier_q <= wdata[IEN_W-1:0];
            if (thr_wr)         pend_q <= 1'b0;
            else if (moved)     pend_q <= 1'b1;
            else if (iid_tx_rd) pend_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (acc.rd) begin
            case (acc.tgt)
                T_RXTX:  rdata = rbr;
                T_DLLO:  rdata = dl_q[0 +: DW];
                T_DLHI:  rdata = dl_q[DW +: DW];
                T_IEN:   rdata = {{(DW-IEN_W){1'b0}}, ier_q};
                T_IID:   rdata = iid;
                T_LCTL:  rdata = lcr_q;
                T_LSTAT: rdata = lstat_pack(dr_q, oe_q, thr_empty);
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/serhost_chk.sv
module serhost_chk (
    input logic       clk,
    input logic       rst,
    input logic       csel_p0,
    input logic       csel_p1,
    input logic       csel_n,
    input logic [2:0] reg_off,
    input logic       rd_strb_n,
    input logic       wr_strb_n,
    input logic [7:0] rdata,
    input logic       rx_valid,
    input logic       tx_valid,
    input logic [7:0] tx_byte,
    input logic       tx_done,
    input logic       irq,
    input logic       dr,
    input logic       thr_empty,
    input logic [3:0] ier
);
    logic sel;
    assign sel = csel_p0 && csel_p1 && !csel_n;

    AST_UNSEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        !sel |-> rdata == 8'h00); // R1
    AST_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!rd_strb_n && !wr_strb_n) |-> rdata == 8'h00); // R2
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_done) |=> (tx_valid && $stable(tx_byte))); // R6
    AST_TX_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!tx_valid && !thr_empty) |=> tx_valid); // R6
    AST_LSTAT_ZEROS: assert property (@(posedge clk) disable iff (rst)
        (sel && !rd_strb_n && wr_strb_n && reg_off == 3'd5) |-> (rdata & 8'hDC) == 8'h00); // R7
    AST_RX_READY: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> dr); // R8
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (ier[1:0] == 2'b00) |-> !irq); // R9
    AST_IID_CODE: assert property (@(posedge clk) disable iff (rst)
        (sel && !rd_strb_n && wr_strb_n && reg_off == 3'd2) |-> $countones(rdata[2:0]) == 1); // R10
endmodule

bind serhost_regs serhost_chk u_chk (
    .clk(clk), .rst(rst), .csel_p0(csel_p0), .csel_p1(csel_p1), .csel_n(csel_n),
    .reg_off(reg_off), .rd_strb_n(rd_strb_n), .wr_strb_n(wr_strb_n), .rdata(rdata),
    .rx_valid(rx_valid), .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_done(tx_done),
    .irq(irq), .dr(dr_q), .thr_empty(thr_empty), .ier(ier_q)
);

// File: tb/tb_serhost_regs.sv
module tb_serhost_regs;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       csel_p0, csel_p1, csel_n;
    logic [2:0] reg_off;
    logic       rd_strb_n, wr_strb_n;
    logic [7:0] wdata, rdata;
    logic       rx_valid, tx_done;
    logic [7:0] rx_byte, tx_byte;
    logic       tx_valid, irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [7:0] last_rd;

    // reference model state
    logic [7:0] m_rbr, m_lcr, m_dll, m_dlm;
    logic [3:0] m_ier;
    bit m_dr, m_oe, m_pend;
    logic [7:0] m_thr[$];
    logic [7:0] m_tsr[$];

    serhost_regs dut (
        .clk(clk), .rst(rst), .csel_p0(csel_p0), .csel_p1(csel_p1), .csel_n(csel_n),
        .reg_off(reg_off), .rd_strb_n(rd_strb_n), .wr_strb_n(wr_strb_n),
        .wdata(wdata), .rdata(rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_done(tx_done), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_sel();
        return csel_p0 && csel_p1 && !csel_n;
    endfunction

    function automatic logic [7:0] m_iid();
        if (m_dr && m_ier[0])        return 8'h04;
        else if (m_pend && m_ier[1]) return 8'h02;
        else                         return 8'h01;
    endfunction

    function automatic logic [7:0] m_read();
        bit dl = m_lcr[7];
        if (!m_sel() || rd_strb_n || !wr_strb_n) return 8'h00;
        case (reg_off)
            3'd0: return dl ? m_dll : m_rbr;
            3'd1: return dl ? m_dlm : {4'h0, m_ier};
            3'd2: return m_iid();
            3'd3: return m_lcr;
            3'd5: return {2'b00, (m_thr.size() == 0), 3'b000, m_oe, m_dr};
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_reset();
        m_rbr = 0; m_lcr = 0; m_dll = 0; m_dlm = 0; m_ier = 0;
        m_dr = 0; m_oe = 0; m_pend = 0;
        m_thr.delete(); m_tsr.delete();
    endtask

    task automatic m_update();
        bit rd = m_sel() && !rd_strb_n && wr_strb_n;
        bit wr = m_sel() && !wr_strb_n && rd_strb_n;
        bit dl = m_lcr[7];
        logic [7:0] iid_pre = m_iid();
        bit moved = (m_thr.size() != 0) && (m_tsr.size() == 0);
        bit rbr_rd = rd && reg_off == 3'd0 && !dl;
        bit lsr_rd = rd && reg_off == 3'd5;
        bit dr_pre = m_dr;
        if (moved) begin
            m_tsr.push_back(m_thr[0]);
            m_thr.delete();
            m_pend = 1;
        end else if (tx_done && m_tsr.size() != 0) begin
            m_tsr.delete();
        end
        if (!moved && rd && reg_off == 3'd2 && iid_pre == 8'h02) m_pend = 0;
        if (rx_valid) begin
            if (dr_pre && !rbr_rd) m_oe = 1;
            else if (lsr_rd) m_oe = 0;
            m_rbr = rx_byte;
            m_dr  = 1;
        end else begin
            if (rbr_rd) m_dr = 0;
            if (lsr_rd) m_oe = 0;
        end
        if (wr) begin
            case (reg_off)
                3'd0: if (dl) m_dll = wdata;
                      else begin m_thr.delete(); m_thr.push_back(wdata); m_pend = 0; end
                3'd1: if (dl) m_dlm = wdata; else m_ier = wdata[3:0];
                3'd3: m_lcr = wdata;
                default: ;
            endcase
        end
    endtask

    // one cycle: inputs already driven at a falling edge
    task automatic step();
        logic [7:0] er;
        #1;
        er = m_read();
        last_rd = rdata;
        chk("R3 rdata vs model", rdata, er);
        @(posedge clk);
        m_update();
        @(negedge clk);
        chk("R6 tx_valid vs model", {7'b0, tx_valid}, {7'b0, (m_tsr.size() != 0)});
        if (m_tsr.size() != 0) chk("R6 tx_byte vs model", tx_byte, m_tsr[0]);
        chk("R9 irq vs model", {7'b0, irq},
            {7'b0, (m_dr && m_ier[0]) || (m_pend && m_ier[1])});
    endtask

    task automatic idle_in();
        csel_p0 = 1; csel_p1 = 1; csel_n = 0;
        rd_strb_n = 1; wr_strb_n = 1; reg_off = 0; wdata = 0;
        rx_valid = 0; rx_byte = 0; tx_done = 0;
    endtask

    task automatic wr_reg(input logic [2:0] o, input logic [7:0] d);
        reg_off = o; wdata = d; wr_strb_n = 0;
        step();
        wr_strb_n = 1;
    endtask

    task automatic rd_reg(input logic [2:0] o);
        reg_off = o; rd_strb_n = 0;
        step();
        rd_strb_n = 1;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_in();
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R11 reset state
        chk("R11 tx_valid after reset", {7'b0, tx_valid}, 8'h00);
        chk("R11 irq after reset", {7'b0, irq}, 8'h00);
        rd_reg(3'd5); chk("R11 R7 line status after reset", last_rd, 8'h20);
        rd_reg(3'd3); chk("R11 line control after reset", last_rd, 8'h00);
        rd_reg(3'd1); chk("R11 enables after reset", last_rd, 8'h00);

        // R4 divisor overlay
        wr_reg(3'd3, 8'h83);
        wr_reg(3'd0, 8'h34);
        wr_reg(3'd1, 8'h12);
        chk("R4 divisor write leaves shift stage idle", {7'b0, tx_valid}, 8'h00);
        rd_reg(3'd0); chk("R4 divisor low", last_rd, 8'h34);
        rd_reg(3'd1); chk("R4 divisor high", last_rd, 8'h12);
        rd_reg(3'd5); chk("R4 holding still empty", last_rd, 8'h20);
        wr_reg(3'd3, 8'h03);
        rd_reg(3'd3); chk("R4 line control readback", last_rd, 8'h03);
        rd_reg(3'd1); chk("R4 enables untouched by divisor", last_rd, 8'h00);

        // R5 enable width
        wr_reg(3'd1, 8'hFF);
        rd_reg(3'd1); chk("R5 upper enable bits zero", last_rd, 8'h0F);
        wr_reg(3'd1, 8'h00);

        // R1 deselect
        csel_n = 1; wr_reg(3'd0, 8'h99);
        chk("R1 deselected write ignored", {7'b0, tx_valid}, 8'h00);
        rd_reg(3'd5); chk("R1 deselected read is zero", last_rd, 8'h00);
        csel_n = 0; csel_p1 = 0; wr_reg(3'd3, 8'hFF); csel_p1 = 1;
        rd_reg(3'd3); chk("R1 partial select ignored", last_rd, 8'h03);

        // R2 both strobes low
        rd_strb_n = 0; wr_reg(3'd3, 8'h80);
        chk("R2 dual strobe rdata zero", last_rd, 8'h00);
        rd_strb_n = 1;
        rd_reg(3'd3); chk("R2 dual strobe no write", last_rd, 8'h03);

        // R3 R6 R7 transmit path
        wr_reg(3'd0, 8'hA5);
        rd_reg(3'd5); chk("R7 holding full clears THRE", last_rd, 8'h00);
        chk("R6 byte moved to shift stage", tx_byte, 8'hA5);
        chk("R6 shift stage valid", {7'b0, tx_valid}, 8'h01);
        rd_reg(3'd5); chk("R7 THRE set after move", last_rd, 8'h20);

        // R6 write in the cycle of a move
        wr_reg(3'd0, 8'h11);
        tx_done = 1; step(); tx_done = 0;
        wr_reg(3'd0, 8'h22);
        chk("R6 moved byte during write", tx_byte, 8'h11);
        rd_reg(3'd5); chk("R6 new byte kept in holding", last_rd, 8'h00);
        tx_done = 1; step(); tx_done = 0;
        step();
        chk("R6 second byte reaches stage", tx_byte, 8'h22);

        // R9 R10 holding-empty interrupt
        wr_reg(3'd1, 8'h02);
        chk("R9 pending holding-empty raises irq", {7'b0, irq}, 8'h01);
        rd_reg(3'd2); chk("R10 id reports holding-empty", last_rd, 8'h02);
        chk("R10 id read clears pending", {7'b0, irq}, 8'h00);
        rd_reg(3'd2); chk("R10 id none", last_rd, 8'h01);
        tx_done = 1; step(); tx_done = 0;

        // R8 receive path
        wr_reg(3'd1, 8'h01);
        rx_valid = 1; rx_byte = 8'h5A; step(); rx_valid = 0;
        chk("R9 data-ready raises irq", {7'b0, irq}, 8'h01);
        rd_reg(3'd5); chk("R8 data-ready in status", last_rd, 8'h21);
        rd_reg(3'd2); chk("R10 id reports data-ready", last_rd, 8'h04);
        rd_reg(3'd0); chk("R3 receive buffer read", last_rd, 8'h5A);
        chk("R8 read clears irq", {7'b0, irq}, 8'h00);
        rx_valid = 1; rx_byte = 8'h66; step();
        rx_byte = 8'h77; rd_reg(3'd0); rx_valid = 0;
        chk("R8 read during arrival returns old", last_rd, 8'h66);
        rd_reg(3'd5); chk("R8 arrival keeps data-ready, no overrun", last_rd, 8'h21);
        rx_valid = 1; rx_byte = 8'h88; step(); rx_valid = 0;
        rd_reg(3'd5); chk("R8 overrun flagged", last_rd, 8'h23);
        rd_reg(3'd5); chk("R8 status read cleared overrun", last_rd, 8'h21);
        rd_reg(3'd0); chk("R8 newest byte kept", last_rd, 8'h88);

        // R12 unused offsets
        wr_reg(3'd7, 8'hFF); wr_reg(3'd5, 8'h00); wr_reg(3'd2, 8'hFF);
        wr_reg(3'd4, 8'hFF); wr_reg(3'd6, 8'hFF);
        rd_reg(3'd7); chk("R12 offset 7 reads zero", last_rd, 8'h00);
        rd_reg(3'd4); chk("R12 offset 4 reads zero", last_rd, 8'h00);
        rd_reg(3'd6); chk("R12 offset 6 reads zero", last_rd, 8'h00);
        rd_reg(3'd3); chk("R12 line control unchanged", last_rd, 8'h03);
        rd_reg(3'd5); chk("R12 status unchanged", last_rd, 8'h20);

        // mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            int op = $urandom_range(0, 9);
            idle_in();
            csel_n  = ($urandom_range(0, 15) == 0);
            reg_off = 3'($urandom_range(0, 7));
            wdata   = 8'($urandom);
            if (op < 4)       rd_strb_n = 0;
            else if (op < 8)  wr_strb_n = 0;
            else if (op == 8) begin rd_strb_n = 0; wr_strb_n = 0; end
            rx_valid = ($urandom_range(0, 4) == 0);
            rx_byte  = 8'($urandom);
            tx_done  = ($urandom_range(0, 2) == 0);
            step();
        end
        idle_in();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule